// File: doc/BRIEF.md
# Set-Associative Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a memory port that is one 32-bit word wide. Fetches arrive as word addresses. The block looks up the indexed set across all ways in the cycle the fetch is accepted. On a hit it returns the stored word on the next cycle. On a miss it chooses a victim way using small per-way usage counters, then reloads the whole line from memory one word per request. The reload starts at the requested word and wraps around inside the line. The requested word is handed back as soon as its beat arrives, but the fetch port stays stalled until the reload has finished.

A fetch goes straight to memory as a single word read, and the cache is left untouched, when any of three things holds: the cache-present input is low, the enable input is low, or the fetch carries the inhibit flag. If memory flags an error during a reload, the line being filled is made invalid and its usage counter is cleared. When the error hits the first beat, the processor also receives an error response.

Top module: `fetch_cache`

## Requirements
- R1: After reset `reqReady` is 1, `rspValid` and `memReqValid` are 0, every way of every set is invalid and every usage counter is 0. The first fetch to any address is therefore a miss.
- R2: A fetch accepted while `cachePresent`=0, `cacheEnable`=0 or `fetchInhibit`=1 issues exactly one memory request at the fetch's own word address. The response returns that beat's data and error flag, and no tag, data word or usage counter changes.
- R3: A cacheable fetch whose tag matches a valid way of its set (set index is word-address bits [SET_W+WORD_W-1:WORD_W], tag the bits above) raises `rspValid` in the cycle right after acceptance, with the stored word and `rspErr`=0, and makes no memory request. At most one way of a set ever matches.
- R4: Each cacheable hit or miss sets the accessed way's counter (the hit way, or the victim on a miss) to MAX_USE-1. Every other way of that set is decremented, except that a counter already at 0 stays at 0.
- R5: On a miss the victim is the way of the set with the smallest usage counter. A tie goes to the lowest way number.
- R6: A miss issues LINE_BYTES/4 memory requests. Request i goes to the line base word address plus ((requested word index + i) mod LINE_BYTES/4). Word addresses are the byte address shifted right by two.
- R7: On a miss the requested word is returned, with `rspValid` for one cycle, in the cycle after the first beat arrives. `reqReady` stays 0 until the last beat has been accepted.
- R8: While `memReqValid` is 1 and `memReqReady` is 0, the request and its address hold steady on the next cycle. Only one memory request is outstanding at a time.
- R9: An error on the first reload beat ends the refill at once. The block returns `rspValid`=1 with `rspErr`=1, leaves the line invalid with its counter at 0, and the next fetch to that line misses.
- R10: An error on a later reload beat ends the refill with no further response to the processor and leaves the line invalid with its counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cachePresent | input | 1 | Cache exists; when low all fetches bypass |
| cacheEnable | input | 1 | Cache enable status; when low all fetches bypass |
| fetchInhibit | input | 1 | This fetch is not to be cached (sampled with the request) |
| reqValid | input | 1 | Fetch request |
| reqWordAddr | input | ADDR_W-2 | Word address of the fetch |
| reqReady | output | 1 | Block accepts a fetch this cycle |
| rspValid | output | 1 | Fetch response strobe |
| rspData | output | 32 | Fetched instruction word |
| rspErr | output | 1 | Fetch ended with a memory error |
| memReqValid | output | 1 | Memory read request |
| memReqAddr | output | ADDR_W-2 | Word address of the memory read |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 32 | Memory read data |
| memRspErr | input | 1 | Memory read failed |

## Verification
A reference model in the bench tracks the tags, valid bits and usage counters. Every fetch is checked against it for the response word, the error flag, hit latency and the exact sequence of memory addresses. Directed patterns come first:
- a fetch into the middle of a line, which shows the wrap-around refill order;
- repeated hits;
- five tags hammering one set, which separates smallest-counter victim choice from round-robin or plain LRU;
- each of the three bypass causes, including a bypass to an address that is already cached;
- errors on the first beat and on a later beat, which show whether the processor is told and whether the line survives.

A long pseudo-random mix of tags, sets, words, bypass flags and an error address then exercises counter saturation and ties across many evictions.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BYP_REQ,
    S_BYP_WAIT,
    S_REF_REQ,
    S_REF_WAIT
  } fetchState_t;

  // Strobes from the sequencer to the storage/datapath
  typedef struct packed {
    logic capture;   // latch the fetch address, clear the beat counter
    logic touchHit;  // hit: age the set, load the stored word
    logic allocate;  // miss: pick victim, write tag, age the set
    logic fill;      // write a refill beat, advance the beat counter
    logic kill;      // invalidate the victim after a memory error
    logic loadMem;   // load the memory word into the response register
  } dpCtrl_t;

endpackage

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 4,
  parameter int LINE_BYTES = 16,
  parameter int MAX_USE    = 4,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-3:0] reqWordAddr,
  input  logic [31:0]       memRspData,
  output logic              lookupHit,
  output logic              lastBeat,
  output logic              beatZero,
  output logic [ADDR_W-3:0] memReqAddr,
  output logic [31:0]       rspData
);

  localparam int WORDS  = LINE_BYTES / 4;
  localparam int WORD_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int CNT_W  = $clog2(MAX_USE);
  localparam int WA_W   = ADDR_W - 2;
  localparam int TAG_W  = WA_W - WORD_W - SET_W;
  localparam logic [CNT_W-1:0]  CNT_TOP   = CNT_W'(MAX_USE - 1);
  localparam logic [WORD_W-1:0] BEAT_LAST = WORD_W'(WORDS - 1);

  logic [TAG_W-1:0] tagArr   [NUM_SETS][NUM_WAYS];
  logic             validArr [NUM_SETS][NUM_WAYS];
  logic [CNT_W-1:0] cntArr   [NUM_SETS][NUM_WAYS];
  logic [31:0]      dataArr  [NUM_SETS][NUM_WAYS][WORDS];

  logic [WA_W-1:0]   addrReg;
  logic [WORD_W-1:0] beat;
  logic [WAY_W-1:0]  victimReg;

  // lookup fields come from the live request address
  logic [SET_W-1:0]  lkSet;
  logic [TAG_W-1:0]  lkTag;
  logic [WORD_W-1:0] lkWord;
  // refill fields come from the captured address
  logic [SET_W-1:0]  rfSet;
  logic [WORD_W-1:0] rfWord;

  assign lkWord = reqWordAddr[WORD_W-1:0];
  assign lkSet  = reqWordAddr[WORD_W +: SET_W];
  assign lkTag  = reqWordAddr[WA_W-1 -: TAG_W];
  assign rfSet  = addrReg[WORD_W +: SET_W];
  assign rfWord = addrReg[WORD_W-1:0] + beat;   // wraps inside the line

  assign memReqAddr = {addrReg[WA_W-1:WORD_W], rfWord};
  assign lastBeat   = (beat == BEAT_LAST);
  assign beatZero   = (beat == '0);

  // ---------------- tag compare across ways ----------------
  logic [NUM_WAYS-1:0] hitVec;
  logic [WAY_W-1:0]    hitWay;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[lkSet][w] && (tagArr[lkSet][w] == lkTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end
  assign lookupHit = |hitVec;

  // ---------------- victim: smallest usage counter ----------------
  logic [WAY_W-1:0] victimWay;
  logic [CNT_W-1:0] minCnt;

  always_comb begin
    victimWay = '0;
    minCnt    = cntArr[lkSet][0];
    for (int w = 1; w < NUM_WAYS; w++) begin
      if (cntArr[lkSet][w] < minCnt) begin
        minCnt    = cntArr[lkSet][w];
        victimWay = WAY_W'(w);
      end
    end
  end

  logic             touch;
  logic [WAY_W-1:0] useWay;
  assign touch  = ctrl.touchHit || ctrl.allocate;
  assign useWay = ctrl.allocate ? victimWay : hitWay;

  // ---------------- valid bits and usage counters ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          validArr[s][w] <= 1'b0;
          cntArr[s][w]   <= '0;
        end
      end
    end else begin
      if (touch) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (WAY_W'(w) == useWay)
            cntArr[lkSet][w] <= CNT_TOP;
          else if (cntArr[lkSet][w] != '0)
            cntArr[lkSet][w] <= cntArr[lkSet][w] - 1'b1;
        end
      end
      if (ctrl.allocate) validArr[lkSet][victimWay] <= 1'b1;
      if (ctrl.kill) begin
        validArr[rfSet][victimReg] <= 1'b0;
        cntArr[rfSet][victimReg]   <= '0;
      end
    end
  end

  // ---------------- tag and data storage (no reset) ----------------
  always_ff @(posedge clk) begin
    if (ctrl.allocate) tagArr[lkSet][victimWay] <= lkTag;
    if (ctrl.fill)     dataArr[rfSet][victimReg][rfWord] <= memRspData;
  end

  // ---------------- address, beat, victim and response registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      beat      <= '0;
      victimReg <= '0;
      rspData   <= '0;
    end else begin
      if (ctrl.capture) begin
        addrReg <= reqWordAddr;
        beat    <= '0;
      end
      if (ctrl.allocate) victimReg <= victimWay;
      if (ctrl.fill)     beat <= beat + 1'b1;
      if (ctrl.touchHit)
        rspData <= dataArr[lkSet][hitWay][lkWord];
      else if (ctrl.loadMem)
        rspData <= memRspData;
    end
  end

  // ---------------- checks ----------------
  logic             chkTouch, chkKill;
  logic [SET_W-1:0] chkSet;
  logic [WAY_W-1:0] chkWay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkTouch <= 1'b0;
      chkKill  <= 1'b0;
      chkSet   <= '0;
      chkWay   <= '0;
    end else begin
      chkTouch <= touch;
      chkKill  <= ctrl.kill;
      chkSet   <= ctrl.kill ? rfSet : lkSet;
      chkWay   <= ctrl.kill ? victimReg : useWay;
    end
  end

  assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_touch_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    chkTouch |-> cntArr[chkSet][chkWay] == CNT_TOP);

  assert_kill_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    chkKill |-> (!validArr[chkSet][chkWay] && cntArr[chkSet][chkWay] == '0));

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_vchk
    assert_victim_min_R5: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.allocate |-> cntArr[lkSet][victimWay] <= cntArr[lkSet][w]);
  end

endmodule

// File: rtl/fc_control.sv
module fc_control
  import fc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cachePresent,
  input  logic    cacheEnable,
  input  logic    fetchInhibit,
  input  logic    reqValid,
  input  logic    lookupHit,
  input  logic    lastBeat,
  input  logic    beatZero,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    memRspErr,
  output logic    reqReady,
  output logic    rspValid,
  output logic    rspErr,
  output logic    memReqValid,
  output dpCtrl_t ctrl
);

  fetchState_t state, stateNext;
  logic accept, bypass, refBeat;

  assign reqReady    = (state == S_IDLE);
  assign accept      = reqReady && reqValid;
  assign bypass      = !cachePresent || !cacheEnable || fetchInhibit;
  assign memReqValid = (state == S_BYP_REQ) || (state == S_REF_REQ);
  assign refBeat     = (state == S_REF_WAIT) && memRspValid;

  always_comb begin
    ctrl          = '0;
    ctrl.capture  = accept;
    ctrl.touchHit = accept && !bypass && lookupHit;
    ctrl.allocate = accept && !bypass && !lookupHit;
    ctrl.fill     = refBeat && !memRspErr;
    ctrl.kill     = refBeat && memRspErr;
    ctrl.loadMem  = ((state == S_BYP_WAIT) && memRspValid) || (refBeat && beatZero);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:
        if (accept) begin
          if (bypass)          stateNext = S_BYP_REQ;
          else if (!lookupHit) stateNext = S_REF_REQ;
        end
      S_BYP_REQ:  if (memReqReady) stateNext = S_BYP_WAIT;
      S_BYP_WAIT: if (memRspValid) stateNext = S_IDLE;
      S_REF_REQ:  if (memReqReady) stateNext = S_REF_WAIT;
      S_REF_WAIT:
        if (memRspValid) stateNext = (memRspErr || lastBeat) ? S_IDLE : S_REF_REQ;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= ctrl.touchHit || ctrl.loadMem;
      rspErr   <= ctrl.loadMem && memRspErr;
    end
  end

  assert_bypass_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && bypass) |=> memReqValid);

  assert_refill_cont_R6: assert property (@(posedge clk) disable iff (!rstN)
    (refBeat && !memRspErr && !lastBeat) |=> (memReqValid && !reqReady));

  assert_err_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (refBeat && memRspErr && beatZero) |=> (rspValid && rspErr && reqReady));

  assert_err_late_R10: assert property (@(posedge clk) disable iff (!rstN)
    (refBeat && memRspErr && !beatZero) |=> (reqReady && !rspValid));

endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
  import fc_pkg::*;
#(
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 4,
  parameter int LINE_BYTES = 16,
  parameter int MAX_USE    = 4,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cachePresent,
  input  logic              cacheEnable,
  input  logic              fetchInhibit,
  input  logic              reqValid,
  input  logic [ADDR_W-3:0] reqWordAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspErr,
  output logic              memReqValid,
  output logic [ADDR_W-3:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  input  logic              memRspErr
);

  dpCtrl_t ctrl;
  logic    lookupHit, lastBeat, beatZero;

  fc_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .cachePresent (cachePresent),
    .cacheEnable  (cacheEnable),
    .fetchInhibit (fetchInhibit),
    .reqValid     (reqValid),
    .lookupHit    (lookupHit),
    .lastBeat     (lastBeat),
    .beatZero     (beatZero),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .memRspErr    (memRspErr),
    .reqReady     (reqReady),
    .rspValid     (rspValid),
    .rspErr       (rspErr),
    .memReqValid  (memReqValid),
    .ctrl         (ctrl)
  );

  fc_datapath #(
    .NUM_SETS   (NUM_SETS),
    .NUM_WAYS   (NUM_WAYS),
    .LINE_BYTES (LINE_BYTES),
    .MAX_USE    (MAX_USE),
    .ADDR_W     (ADDR_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqWordAddr (reqWordAddr),
    .memRspData  (memRspData),
    .lookupHit   (lookupHit),
    .lastBeat    (lastBeat),
    .beatZero    (beatZero),
    .memReqAddr  (memReqAddr),
    .rspData     (rspData)
  );

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

endmodule

// File: tb/fetch_cache_test.sv
module fetch_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int WORDS = 4;
  localparam int MAXU = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cachePresent = 1'b1, cacheEnable = 1'b1, fetchInhibit = 1'b0;
  logic        reqValid = 1'b0;
  logic [29:0] reqWordAddr = '0;
  logic        reqReady, rspValid, rspErr, memReqValid;
  logic [31:0] rspData;
  logic [29:0] memReqAddr;
  logic        memReqReady = 1'b0, memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_cache uut (
    .clk(clk), .rstN(rstN), .cachePresent(cachePresent), .cacheEnable(cacheEnable),
    .fetchInhibit(fetchInhibit), .reqValid(reqValid), .reqWordAddr(reqWordAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int mTag   [SETS][WAYS];
  bit mValid [SETS][WAYS];
  int mCnt   [SETS][WAYS];

  bit          errOn = 0;
  logic [29:0] errWord = '0;
  logic [29:0] seenQ[$];

  function automatic logic [31:0] memWord(logic [29:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [29:0] mk(int tg, int st, int wd);
    return {26'(tg), 2'(st), 2'(wd)};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic touchModel(int st, int way);
    for (int w = 0; w < WAYS; w++) begin
      if (w == way) mCnt[st][w] = MAXU - 1;
      else if (mCnt[st][w] > 0) mCnt[st][w]--;
    end
  endtask

  // memory responder: one request at a time, one-cycle accept, one-cycle data
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      if (memReqReady) begin
        memReqReady = 1'b0;
        memRspValid = 1'b1;
        memRspData  = memWord(memReqAddr);
        memRspErr   = errOn && (memReqAddr == errWord);
        seenQ.push_back(memReqAddr);
      end else if (memReqValid) begin
        memReqReady = 1'b1;
      end
    end
  end

  task automatic fetch(input logic [29:0] wa, input bit pres, input bit en, input bit inh);
    logic [29:0] expQ[$];
    int st, tg, wd, hitW, vic, minC, cyc;
    bit byp, isHit, firstErr, expErr, extra;
    logic [31:0] expData;
    string tagD;
    st = int'(wa[3:2]); tg = int'(wa[29:4]); wd = int'(wa[1:0]);
    byp = !pres || !en || inh;
    isHit = 0; firstErr = 0; expErr = 0; expData = memWord(wa);
    if (byp) begin
      expQ.push_back(wa);
      expErr = errOn && (wa == errWord);
      firstErr = expErr;
      tagD = "R2";
    end else begin
      hitW = -1;
      for (int w = 0; w < WAYS; w++)
        if (mValid[st][w] && mTag[st][w] == tg) hitW = w;
      if (hitW >= 0) begin
        isHit = 1; tagD = "R3";
        touchModel(st, hitW);
      end else begin
        tagD = "R7";
        vic = 0; minC = mCnt[st][0];
        for (int w = 1; w < WAYS; w++)
          if (mCnt[st][w] < minC) begin minC = mCnt[st][w]; vic = w; end
        touchModel(st, vic);
        mValid[st][vic] = 1; mTag[st][vic] = tg;
        for (int i = 0; i < WORDS; i++) begin
          logic [29:0] a;
          a = {wa[29:2], 2'(wd + i)};
          expQ.push_back(a);
          if (errOn && a == errWord) begin
            mValid[st][vic] = 0; mCnt[st][vic] = 0;
            if (i == 0) begin expErr = 1; firstErr = 1; tagD = "R9"; end
            break;
          end
        end
      end
    end

    @(negedge clk);
    check(reqReady == 1'b1, "R7", "ready before fetch", reqReady, 1);
    seenQ.delete();
    reqValid = 1'b1; reqWordAddr = wa;
    cachePresent = pres; cacheEnable = en; fetchInhibit = inh;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    while (!rspValid && cyc < 60) begin @(negedge clk); cyc++; end
    check(rspValid == 1'b1, tagD, "response seen", rspValid, 1);
    if (isHit) check(cyc == 1, "R3", "hit latency", cyc, 1);
    check(rspData == expData, tagD, "response data", rspData, expData);
    check(rspErr == expErr, tagD, "response error flag", rspErr, expErr);
    if (!byp && !isHit && !firstErr)
      check(reqReady == 1'b0, "R7", "stall during refill", reqReady, 0);
    extra = 0; cyc = 0;
    while (!reqReady && cyc < 100) begin
      @(negedge clk); cyc++;
      if (rspValid) extra = 1;
    end
    check(extra == 0, "R10", "no second response", extra, 0);
    check(seenQ.size() == expQ.size(), "R4 R5 R6", "memory request count",
          seenQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < seenQ.size(); i++)
      check(seenQ[i] == expQ[i], "R6", "memory request address", seenQ[i], expQ[i]);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mTag[s][w] = 0; mValid[s][w] = 0; mCnt[s][w] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check(rspValid == 1'b0, "R1", "rspValid after reset", rspValid, 0);
    check(memReqValid == 1'b0, "R1", "memReqValid after reset", memReqValid, 0);

    // R1/R6 first miss, wrap order 2,3,0,1
    fetch(mk(1, 0, 2), 1, 1, 0);
    // R3 hits
    fetch(mk(1, 0, 0), 1, 1, 0);
    fetch(mk(1, 0, 3), 1, 1, 0);
    // R4 R5 fill the set and evict by usage counters
    fetch(mk(2, 0, 1), 1, 1, 0);
    fetch(mk(3, 0, 0), 1, 1, 0);
    fetch(mk(4, 0, 3), 1, 1, 0);
    fetch(mk(1, 0, 1), 1, 1, 0);
    fetch(mk(5, 0, 0), 1, 1, 0);
    fetch(mk(2, 0, 2), 1, 1, 0);
    fetch(mk(1, 0, 2), 1, 1, 0);
    fetch(mk(5, 0, 1), 1, 1, 0);
    // R2 each bypass cause, including to a cached line
    fetch(mk(1, 0, 1), 0, 1, 0);
    fetch(mk(1, 0, 1), 1, 0, 0);
    fetch(mk(1, 0, 1), 1, 1, 1);
    fetch(mk(7, 1, 0), 1, 1, 1);
    fetch(mk(7, 1, 0), 1, 1, 0);
    // R9 error on first beat
    errOn = 1; errWord = mk(8, 2, 1);
    fetch(mk(8, 2, 1), 1, 1, 0);
    errOn = 0;
    fetch(mk(8, 2, 1), 1, 1, 0);
    // R10 error on a later beat (order 2,3,0)
    errOn = 1; errWord = mk(9, 3, 0);
    fetch(mk(9, 3, 2), 1, 1, 0);
    errOn = 0;
    fetch(mk(9, 3, 2), 1, 1, 0);
    // R2 bypass error
    errOn = 1; errWord = mk(10, 1, 1);
    fetch(mk(10, 1, 1), 1, 0, 0);

    // mixed pseudo-random traffic
    errWord = mk(3, 2, 2);
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      fetch(mk(int'(lfsr[2:0]) % 6, int'(lfsr[9:8]), int'(lfsr[5:4])),
            lfsr[17:12] != 0, lfsr[23:18] != 0, lfsr[27:24] == 0);
    end
    finishRun();
  end

endmodule